// File: doc/BRIEF.md
# Serial Flag-Offset Register Port

This block stores the two threshold offsets that a FIFO's flag logic uses to raise its almost-empty and almost-full warnings. Both offsets sit in one bit chain. Software or a test controller writes the chain one bit at a time on a serial data input, and reads it back one bit at a time on a serial data output. Both directions run on a dedicated serial clock. The stored values are always present as two parallel words for the flag comparators.

Master reset loads a preset value into both offsets. Two select pins choose the preset from a table of four. Partial reset leaves the stored offsets as they are and only returns both serial positions to the start of the chain. The chain is `2*OFS_W` bits long. Bits `0 .. OFS_W-1` hold the almost-empty offset and bits `OFS_W .. 2*OFS_W-1` hold the almost-full offset. Each offset travels least significant bit first.

Top module: `flag_offset_serial_port`

## Requirements
- R1: While master reset is high at a serial clock rising edge, both offsets take the preset chosen by the select pins at that edge. The preset is 7 for select code 0, 31 for code 1, 63 for code 2 and 127 for code 3.
- R2: On the k-th rising edge (k counted from 0) at which serial load is enabled, the serial input is written into chain bit k. Chain bits 0 to OFS_W-1 are the almost-empty offset, least significant bit first. The following bits are the almost-full offset, least significant bit first. The parallel outputs show the new bit right after that edge.
- R3: On the k-th rising edge at which serial read is enabled and serial load is not, the serial output takes chain bit k.
- R4: After 2*OFS_W bits have moved in one direction, further rising edges with that enable still high change nothing. The offsets stay the same after a full load, and the serial output holds after a full read.
- R5: Dropping an enable for at least one rising edge makes the next enabled transfer in that direction start again at chain bit 0.
- R6: When load and read are enabled together, the load goes ahead as in R2. The serial output holds its value and the read position does not advance.
- R7: Partial reset leaves both offsets unchanged and returns both serial positions to chain bit 0. No bit is written or read on a partial-reset edge.
- R8: A load stopped after n bits changes only chain bits 0 to n-1.
- R9: The serial output is 0 after master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. All state changes on its rising edge. |
| mrst | input | 1 | Master reset, synchronous, active high. |
| prst | input | 1 | Partial reset, synchronous, active high. |
| dsel | input | 2 | Chooses the preset loaded by master reset. |
| sload_en | input | 1 | Serial load enable. |
| sread_en | input | 1 | Serial read enable. |
| sdin | input | 1 | Serial data input. |
| sdout | output | 1 | Serial data output, registered. |
| ae_ofs | output | OFS_W | Almost-empty offset. |
| af_ofs | output | OFS_W | Almost-full offset. |

## Verification
The bench builds the block with OFS_W = 8, which gives a 16-bit chain. At that width, every one of the 256 almost-empty values can be loaded, paired with its bit complement as the almost-full value, and read back over the whole chain, including the clocks after the end of the chain. The same small chain lets the bench check all four presets, a partial load, simultaneous load and read, and partial reset in the middle of a read against a bit-level model of the chain.

// File: rtl/ofs_serial_pkg.sv
package ofs_serial_pkg;

   localparam int unsigned NUM_PRESETS = 4;

   typedef logic [1:0] preset_sel_t;

   // True when value v can be held in w bits.
   function automatic bit value_fits(int unsigned v, int unsigned w);
      if (w >= 32) return 1'b1;
      return v < (32'd1 << w);
   endfunction

endpackage

// File: rtl/ofs_preset_table.sv
module ofs_preset_table
   import ofs_serial_pkg::*;
#(
   parameter int unsigned OFS_W = 16,
   parameter int unsigned PRESETS [NUM_PRESETS] = '{7, 31, 63, 127}
) (
   input  preset_sel_t      sel,
   output logic [OFS_W-1:0] value
);

   logic [OFS_W-1:0] table_q [NUM_PRESETS];

   for (genvar i = 0; i < NUM_PRESETS; i++) begin : g_entry
      if (!value_fits(PRESETS[i], OFS_W)) begin : g_bad
         $error("preset %0d does not fit the offset width", i);
      end
      assign table_q[i] = OFS_W'(PRESETS[i]);
   end

   assign value = table_q[sel];

endmodule

// File: rtl/ofs_bit_counter.sv
module ofs_bit_counter #(
   parameter  int unsigned LIMIT = 32,
   localparam int unsigned CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          arm,
   input  logic          step,
   output logic [CW-1:0] idx,
   output logic          done,
   output logic          adv
);

   if (LIMIT < 2) begin : g_bad_limit
      $error("counter limit must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign idx  = cnt_q;
   assign done = (cnt_q == CW'(LIMIT));
   assign adv  = arm && step && !done && !clr;

   always_ff @(posedge clk) begin
      if (clr || !arm) cnt_q <= '0;
      else if (adv)    cnt_q <= cnt_q + 1'b1;
   end

   assert_idx_bound_R4: assert property (@(posedge clk) disable iff (clr)
      idx <= CW'(LIMIT));

   assert_stay_done_R4: assert property (@(posedge clk) disable iff (clr)
      (arm && done) |=> done);

   assert_restart_R5: assert property (@(posedge clk) disable iff (clr)
      !arm |=> (idx == '0));

endmodule

// File: rtl/ofs_chain_store.sv
module ofs_chain_store #(
   parameter  int unsigned OFS_W = 16,
   localparam int unsigned CH_W  = 2 * OFS_W,
   localparam int unsigned CW    = $clog2(CH_W + 1),
   localparam int unsigned IW    = $clog2(CH_W)
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic [OFS_W-1:0] preset,
   input  logic             wr_adv,
   input  logic [CW-1:0]    wr_idx,
   input  logic             wr_bit,
   input  logic             rd_adv,
   input  logic [CW-1:0]    rd_idx,
   output logic [CH_W-1:0]  chain,
   output logic             sdout
);

   logic [CH_W-1:0] hit;
   logic [CH_W-1:0] chain_q;
   logic            sdout_q;

   for (genvar b = 0; b < CH_W; b++) begin : g_hit
      assign hit[b] = wr_adv && (wr_idx == CW'(b));
   end

   always_ff @(posedge clk) begin
      if (mrst) chain_q <= {preset, preset};
      else      chain_q <= (chain_q & ~hit) | ({CH_W{wr_bit}} & hit);
   end

   always_ff @(posedge clk) begin
      if (mrst)        sdout_q <= 1'b0;
      else if (rd_adv) sdout_q <= chain_q[rd_idx[IW-1:0]];
   end

   assign chain = chain_q;
   assign sdout = sdout_q;

   assert_one_bit_R8: assert property (@(posedge clk) disable iff (mrst)
      $countones(hit) <= 1);

   assert_load_bit_R2: assert property (@(posedge clk) disable iff (mrst)
      wr_adv |=> (chain_q[$past(wr_idx[IW-1:0])] == $past(wr_bit)));

   assert_idle_keep_R8: assert property (@(posedge clk) disable iff (mrst)
      !wr_adv |=> $stable(chain_q));

endmodule

// File: rtl/flag_offset_serial_port.sv
module flag_offset_serial_port
   import ofs_serial_pkg::*;
#(
   parameter  int unsigned OFS_W = 16,
   parameter  int unsigned PRESETS [NUM_PRESETS] = '{7, 31, 63, 127},
   localparam int unsigned CH_W  = 2 * OFS_W,
   localparam int unsigned CW    = $clog2(CH_W + 1)
) (
   input  logic             sclk,
   input  logic             mrst,
   input  logic             prst,
   input  logic [1:0]       dsel,
   input  logic             sload_en,
   input  logic             sread_en,
   input  logic             sdin,
   output logic             sdout,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs
);

   if (OFS_W < 2) begin : g_bad_width
      $error("offset width must be at least 2");
   end

   logic             clr;
   logic [OFS_W-1:0] preset;
   logic [CW-1:0]    wr_idx, rd_idx;
   logic             wr_done, rd_done, wr_adv, rd_adv;
   logic [CH_W-1:0]  chain;

   assign clr = mrst || prst;

   ofs_preset_table #(.OFS_W(OFS_W), .PRESETS(PRESETS)) u_presets (
      .sel   (dsel),
      .value (preset)
   );

   ofs_bit_counter #(.LIMIT(CH_W)) u_wr_cnt (
      .clk  (sclk),
      .clr  (clr),
      .arm  (sload_en),
      .step (1'b1),
      .idx  (wr_idx),
      .done (wr_done),
      .adv  (wr_adv)
   );

   // A read step waits whenever a load is enabled (load has priority).
   ofs_bit_counter #(.LIMIT(CH_W)) u_rd_cnt (
      .clk  (sclk),
      .clr  (clr),
      .arm  (sread_en),
      .step (!sload_en),
      .idx  (rd_idx),
      .done (rd_done),
      .adv  (rd_adv)
   );

   ofs_chain_store #(.OFS_W(OFS_W)) u_store (
      .clk    (sclk),
      .mrst   (mrst),
      .preset (preset),
      .wr_adv (wr_adv),
      .wr_idx (wr_idx),
      .wr_bit (sdin),
      .rd_adv (rd_adv),
      .rd_idx (rd_idx),
      .chain  (chain),
      .sdout  (sdout)
   );

   assign ae_ofs = chain[OFS_W-1:0];
   assign af_ofs = chain[CH_W-1:OFS_W];

   assert_preset_R1: assert property (@(posedge sclk)
      mrst |=> (ae_ofs == OFS_W'(PRESETS[$past(dsel)]))
               && (af_ofs == OFS_W'(PRESETS[$past(dsel)])));

   assert_sdout_clear_R9: assert property (@(posedge sclk)
      mrst |=> (sdout == 1'b0));

   assert_prst_keep_R7: assert property (@(posedge sclk) disable iff (mrst)
      prst |=> ($stable(ae_ofs) && $stable(af_ofs)));

   assert_both_hold_R6: assert property (@(posedge sclk) disable iff (mrst)
      (sload_en && sread_en) |=> $stable(sdout));

   assert_full_load_R4: assert property (@(posedge sclk) disable iff (mrst)
      (sload_en && wr_done) |=> ($stable(ae_ofs) && $stable(af_ofs)));

   assert_full_read_R4: assert property (@(posedge sclk) disable iff (mrst)
      (sread_en && rd_done) |=> $stable(sdout));

   assert_read_bit_R3: assert property (@(posedge sclk) disable iff (mrst)
      (sread_en && !sload_en && !rd_done && !prst)
         |=> (sdout == $past(chain[rd_idx[$clog2(CH_W)-1:0]])));

endmodule

// File: tb/sim_flag_offset_serial_port.sv
module sim_flag_offset_serial_port;

   localparam int unsigned W  = 8;
   localparam int unsigned CH = 2 * W;

   logic         sclk = 1'b0;
   logic         mrst = 1'b1;
   logic         prst = 1'b0;
   logic [1:0]   dsel = 2'd0;
   logic         sload_en = 1'b0;
   logic         sread_en = 1'b0;
   logic         sdin = 1'b0;
   logic         sdout;
   logic [W-1:0] ae_ofs, af_ofs;

   int unsigned  n_chk  = 0;
   int unsigned  n_fail = 0;
   logic [CH-1:0] m;   // bench model of the chain

   always #5 sclk = ~sclk;

   flag_offset_serial_port #(.OFS_W(W)) u0 (
      .sclk     (sclk),
      .mrst     (mrst),
      .prst     (prst),
      .dsel     (dsel),
      .sload_en (sload_en),
      .sread_en (sread_en),
      .sdin     (sdin),
      .sdout    (sdout),
      .ae_ofs   (ae_ofs),
      .af_ofs   (af_ofs)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge sclk);
      #1;
   endtask

   task automatic chk_ofs(input string req);
      chk({af_ofs, ae_ofs} == m, req, {16'd0, af_ofs, ae_ofs}, {16'd0, m});
   endtask

   function automatic int unsigned preset_of(input int unsigned s);
      case (s)
         0: return 7;
         1: return 31;
         2: return 63;
         default: return 127;
      endcase
   endfunction

   task automatic do_mrst(input int unsigned s);
      @(negedge sclk);
      mrst = 1'b1; dsel = 2'(s);
      tick();
      @(negedge sclk);
      mrst = 1'b0;
      m = {W'(preset_of(s)), W'(preset_of(s))};
      chk_ofs("R1");
      chk(sdout == 1'b0, "R9", 32'(sdout), 32'd0);
   endtask

   // Load the first n bits of value v; the enable then drops for one edge.
   task automatic do_load(input logic [CH-1:0] v, input int unsigned n);
      for (int k = 0; k < int'(n); k++) begin
         @(negedge sclk);
         sload_en = 1'b1; sdin = v[k];
         m[k] = v[k];
      end
      @(negedge sclk);
      sload_en = 1'b0;
      tick();
      chk_ofs(n == CH ? "R2" : "R8");
   endtask

   // Read the whole chain, then keep clocking past its end.
   task automatic do_read();
      for (int k = 0; k < int'(CH); k++) begin
         @(negedge sclk);
         sread_en = 1'b1;
         tick();
         chk(sdout == m[k], "R3", 32'(sdout), 32'(m[k]));
      end
      for (int k = 0; k < 3; k++) begin
         tick();
         chk(sdout == m[CH-1], "R4", 32'(sdout), 32'(m[CH-1]));
      end
      @(negedge sclk);
      sread_en = 1'b0;
   endtask

   initial begin : watchdog
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [CH-1:0] v;
      tick();
      // R1, R9: every preset code
      for (int s = 0; s < 4; s++) begin
         do_mrst(s);
         do_read();
      end

      // R2, R3, R5: every almost-empty value with complement almost-full
      for (int a = 0; a < 256; a++) begin
         v = {~W'(a), W'(a)};
         do_load(v, CH);
         do_read();
      end

      // R4: clocks after a full load change nothing
      v = 16'hA55A;
      @(negedge sclk);
      for (int k = 0; k < int'(CH) + 4; k++) begin
         sload_en = 1'b1; sdin = (k < int'(CH)) ? v[k] : ~v[k - CH];
         @(negedge sclk);
      end
      sload_en = 1'b0;
      m = v;
      tick();
      chk_ofs("R4");

      // R8: partial load touches only the first bits
      do_load(16'h00FF ^ m, 5);
      do_read();

      // R6: load and read together
      @(negedge sclk);
      for (int k = 0; k < 3; k++) begin
         sread_en = 1'b1;
         tick();
         chk(sdout == m[k], "R3", 32'(sdout), 32'(m[k]));
         @(negedge sclk);
      end
      for (int k = 0; k < 2; k++) begin
         sload_en = 1'b1; sdin = ~m[k];
         m[k] = ~m[k];
         tick();
         chk(sdout == m[2], "R6", 32'(sdout), 32'(m[2]));
         chk_ofs("R6");
         @(negedge sclk);
      end
      sload_en = 1'b0;
      tick();
      chk(sdout == m[3], "R6", 32'(sdout), 32'(m[3]));
      @(negedge sclk);
      sread_en = 1'b0;

      // R7: partial reset in the middle of a read and a load
      @(negedge sclk);
      for (int k = 0; k < 4; k++) begin
         sread_en = 1'b1;
         @(negedge sclk);
      end
      prst = 1'b1; sread_en = 1'b0; sload_en = 1'b1; sdin = ~m[0];
      tick();
      chk_ofs("R7");
      @(negedge sclk);
      prst = 1'b0; sload_en = 1'b0;
      tick();
      chk_ofs("R7");
      do_read();

      // R1 again after user data, code 3
      do_mrst(3);
      do_read();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule